// File: doc/BRIEF.md
# FP Pipe Operand Read-Port Allocator

This block sits between the floating-point/vector scheduler and the register file. Each cycle up to four execution pipes, numbered FP0 to FP3, may each offer one micro-op. Every offer carries an operation class and up to three source register indices. The block decides which offers issue and steers their source indices onto the register-file read ports. It also flags which granted pipes will need a write port. Its decisions are registered, so they come out one clock after the request.

The parameter `REDUCED` chooses between two layouts. The full layout has eight read ports and four pipes. In that layout a fused multiply-add on FP0 or FP1 borrows the source bus of FP3 for its third operand, so FP3 must stand aside. The reduced layout has six read ports. It drops FP3 altogether, limits FP1 to two-source math and turns FP2 into a store-only pipe. FP0 keeps a private read port for its third operand. An offer whose class its pipe cannot run in the active layout never issues, and it raises a per-pipe error flag.

Top module: `fp_rdport_alloc`

## Requirements
- R1: Full layout (`REDUCED`=0), eight read ports. Source slots a and b of pipe p use ports 2p and 2p+1. The third source of a fused multiply-add on FP0 or FP1 uses port 6. `rd_pipe_o` names the pipe that owns each enabled port.
- R2: Reduced layout (`REDUCED`=1), six read ports. FP0 uses ports 0, 1 and 2 (port 2 holds its third source), FP1 uses ports 3 and 4, and the FP2 store uses port 5. FP3 is never granted and never enables a write.
- R3: Class codes are 0 two-source math, 1 fused multiply-add, 2 store and 3 reserved. In the full layout FP0 and FP1 take codes 0 and 1, FP2 takes 0 and 2, and FP3 takes 0. In the reduced layout FP0 takes 0 and 1, FP1 takes 0, FP2 takes 2, and FP3 takes nothing. A valid offer the pipe cannot take is never granted and sets `bad_op_o` for that pipe. A legal offer is granted unless R4 or R5 holds it.
- R4: In the full layout, a granted fused multiply-add on FP0 or FP1 leaves FP3 without a grant in that cycle.
- R5: In the full layout, when FP0 and FP1 both offer a fused multiply-add, FP0 is granted and FP1 is held.
- R6: A granted store enables only the port of source slot a and never sets its write enable.
- R7: `wr_en_o` is set only for granted pipes whose class is not a store.
- R8: Grants, error flags, write enables and port lines update one clock after the request. Ports not in use show enable 0, address 0 and pipe 0.
- R9: While `rst_i` is high, all outputs are zero at each clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_vld_i | input | 4 | Per-pipe offer valid, bit p for FPp |
| req_op_i | input | 8 | Per-pipe class code, bits 2p+1:2p |
| req_src_i | input | 12*REG_AW | Source indices; slot s of pipe p is at (3p+s)*REG_AW |
| gnt_o | output | 4 | Registered per-pipe grant |
| wr_en_o | output | 4 | Registered per-pipe write-port enable |
| bad_op_o | output | 4 | Registered per-pipe unsupported-class flag |
| rd_en_o | output | NRP | Read-port enables (8 full, 6 reduced) |
| rd_addr_o | output | NRP*REG_AW | Read-port register index, port k at k*REG_AW |
| rd_pipe_o | output | NRP*2 | Pipe that owns each read port, port k at 2k |

## Verification
The bench drives one instance of each layout with the same stimulus. It targets the cases where FP3 collides with a borrowed bus. If the FP3 hold were missing, port 6 would carry two sources, and the address and grant checks would both fail. It also sends two fused multiply-adds at once. A design with the priority reversed, or one that granted both, would show the wrong grant on FP1 or a corrupted port 6. Stores on FP2 are checked for a spurious write enable and for a second read port. The reserved class and classes that are legal in one layout but not the other are checked as well. A wrong legality table shows up as a grant paired with a missing error flag.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

    typedef enum logic [1:0] {
        OP_MATH2 = 2'd0,
        OP_FMA   = 2'd1,
        OP_STORE = 2'd2,
        OP_RSVD  = 2'd3
    } op_cls_e;

    localparam int NUM_PIPES = 4;
    localparam int NUM_SLOTS = 3;
    localparam int PIPE_IDW  = 2;

    function automatic int rd_ports(bit reduced);
        return reduced ? 6 : 8;
    endfunction

    function automatic int slots_used(op_cls_e op);
        case (op)
            OP_STORE: return 1;
            OP_MATH2: return 2;
            OP_FMA:   return 3;
            default:  return 0;
        endcase
    endfunction

    function automatic logic op_legal(bit reduced, int pipe, op_cls_e op);
        logic r;
        r = 1'b0;
        if (op != OP_RSVD) begin
            if (!reduced) begin
                case (pipe)
                    0, 1:    r = (op != OP_STORE);
                    2:       r = (op != OP_FMA);
                    3:       r = (op == OP_MATH2);
                    default: r = 1'b0;
                endcase
            end else begin
                case (pipe)
                    0:       r = (op != OP_STORE);
                    1:       r = (op == OP_MATH2);
                    2:       r = (op == OP_STORE);
                    default: r = 1'b0;
                endcase
            end
        end
        return r;
    endfunction

    // read port carrying slot s of pipe p, or -1 when the layout has none
    function automatic int port_of(bit reduced, int pipe, int slot);
        if (!reduced) begin
            if (slot < 2) return 2 * pipe + slot;
            if (pipe < 2) return 6;
            return -1;
        end
        case (pipe)
            0:       return slot;
            1:       return (slot < 2) ? 3 + slot : -1;
            2:       return (slot == 0) ? 5 : -1;
            default: return -1;
        endcase
    endfunction

endpackage

// File: rtl/fpa_class_check.sv
module fpa_class_check
    import fpa_pkg::*;
#(
    parameter bit REDUCED = 1'b0,
    parameter int PIPE    = 0
) (
    input  logic       vld_i,
    input  logic [1:0] op_i,
    output logic       ok_o,
    output logic       bad_o
);
    logic legal;

    assign legal = op_legal(REDUCED, PIPE, op_cls_e'(op_i));
    assign ok_o  = vld_i & legal;
    assign bad_o = vld_i & ~legal;
endmodule

// File: rtl/fpa_arbiter.sv
module fpa_arbiter
    import fpa_pkg::*;
#(
    parameter bit REDUCED = 1'b0
) (
    input  logic [NUM_PIPES-1:0] ok_i,
    input  logic [NUM_PIPES-1:0] fma_i,
    output logic [NUM_PIPES-1:0] gnt_o
);
    always_comb begin
        gnt_o = ok_i;
        // third-source bus is shared with FP3 only in the full layout
        if (!REDUCED && fma_i[0] && fma_i[1]) gnt_o[1] = 1'b0;
        if (!REDUCED && (fma_i[0] || fma_i[1])) gnt_o[3] = 1'b0;
    end
endmodule

// File: rtl/fpa_port_router.sv
module fpa_port_router
    import fpa_pkg::*;
#(
    parameter bit REDUCED = 1'b0,
    parameter int REG_AW  = 8,
    parameter int NRP     = 8
) (
    input  logic [NUM_PIPES-1:0]                          gnt_i,
    input  logic [NUM_PIPES-1:0][1:0]                     op_i,
    input  logic [NUM_PIPES-1:0][NUM_SLOTS-1:0][REG_AW-1:0] src_i,
    output logic [NRP-1:0]                                en_o,
    output logic [NRP-1:0][REG_AW-1:0]                    addr_o,
    output logic [NRP-1:0][PIPE_IDW-1:0]                  pipe_o
);
    always_comb begin
        en_o   = '0;
        addr_o = '0;
        pipe_o = '0;
        for (int k = 0; k < NRP; k++) begin
            for (int p = 0; p < NUM_PIPES; p++) begin
                for (int s = 0; s < NUM_SLOTS; s++) begin
                    if (gnt_i[p] && (s < slots_used(op_cls_e'(op_i[p])))
                        && (port_of(REDUCED, p, s) == k)) begin
                        en_o[k]   = 1'b1;
                        addr_o[k] = src_i[p][s];
                        pipe_o[k] = PIPE_IDW'(p);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/fp_rdport_alloc.sv
module fp_rdport_alloc
    import fpa_pkg::*;
#(
    parameter bit REDUCED = 1'b0,
    parameter int REG_AW  = 8,
    localparam int NRP    = rd_ports(REDUCED)
) (
    input  logic                                  clk_i,
    input  logic                                  rst_i,
    input  logic [NUM_PIPES-1:0]                  req_vld_i,
    input  logic [2*NUM_PIPES-1:0]                req_op_i,
    input  logic [NUM_PIPES*NUM_SLOTS*REG_AW-1:0] req_src_i,
    output logic [NUM_PIPES-1:0]                  gnt_o,
    output logic [NUM_PIPES-1:0]                  wr_en_o,
    output logic [NUM_PIPES-1:0]                  bad_op_o,
    output logic [NRP-1:0]                        rd_en_o,
    output logic [NRP*REG_AW-1:0]                 rd_addr_o,
    output logic [NRP*PIPE_IDW-1:0]               rd_pipe_o
);
    logic [NUM_PIPES-1:0]      ok_c, bad_c, fma_c, gnt_c, wr_c;
    logic [NUM_PIPES-1:0][1:0] op_c;
    logic [NUM_PIPES-1:0][NUM_SLOTS-1:0][REG_AW-1:0] src_c;
    logic [NRP-1:0]                   en_c;
    logic [NRP-1:0][REG_AW-1:0]       addr_c;
    logic [NRP-1:0][PIPE_IDW-1:0]     pipe_c;

    assign op_c  = req_op_i;
    assign src_c = req_src_i;

    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
        fpa_class_check #(.REDUCED(REDUCED), .PIPE(p)) u_cls (
            .vld_i (req_vld_i[p]),
            .op_i  (op_c[p]),
            .ok_o  (ok_c[p]),
            .bad_o (bad_c[p])
        );
        assign fma_c[p] = ok_c[p] && (op_cls_e'(op_c[p]) == OP_FMA);
        assign wr_c[p]  = gnt_c[p] && (op_cls_e'(op_c[p]) != OP_STORE);
    end

    fpa_arbiter #(.REDUCED(REDUCED)) u_arb (
        .ok_i  (ok_c),
        .fma_i (fma_c),
        .gnt_o (gnt_c)
    );

    fpa_port_router #(.REDUCED(REDUCED), .REG_AW(REG_AW), .NRP(NRP)) u_route (
        .gnt_i  (gnt_c),
        .op_i   (op_c),
        .src_i  (src_c),
        .en_o   (en_c),
        .addr_o (addr_c),
        .pipe_o (pipe_c)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            gnt_o     <= '0;
            wr_en_o   <= '0;
            bad_op_o  <= '0;
            rd_en_o   <= '0;
            rd_addr_o <= '0;
            rd_pipe_o <= '0;
        end else begin
            gnt_o     <= gnt_c;
            wr_en_o   <= wr_c;
            bad_op_o  <= bad_c;
            rd_en_o   <= en_c;
            rd_addr_o <= addr_c;
            rd_pipe_o <= pipe_c;
        end
    end
endmodule

// File: rtl/fpa_checker.sv
module fpa_checker #(
    parameter bit REDUCED = 1'b0
) (
    input logic       clk_i,
    input logic       rst_i,
    input logic [3:0] req_vld_i,
    input logic [7:0] req_op_i,
    input logic [3:0] gnt_o,
    input logic [3:0] wr_en_o,
    input logic [3:0] bad_op_o
);
    AST_GNT_BAD_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
        (gnt_o & bad_op_o) == 4'd0);                                            // R3
    AST_RSVD_FLAGGED: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_vld_i[0] && req_op_i[1:0] == 2'd3) |=> (bad_op_o[0] && !gnt_o[0])); // R3
    AST_FP3_ONLY_MATH: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_vld_i[3] && req_op_i[7:6] != 2'd0) |=> !gnt_o[3]);                 // R3
    AST_WR_NEEDS_GNT: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_o & ~gnt_o) == 4'd0);                                            // R7
    AST_STORE_NO_WR: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_vld_i[2] && req_op_i[5:4] == 2'd2) |=> !wr_en_o[2]);               // R6
    AST_FP0_MATH_NEXT: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_vld_i[0] && req_op_i[1:0] == 2'd0) |=> gnt_o[0]);                  // R8

    if (!REDUCED) begin : g_full
        AST_FMA_HOLDS_FP3: assert property (@(posedge clk_i) disable iff (rst_i)
            ((req_vld_i[0] && req_op_i[1:0] == 2'd1) ||
             (req_vld_i[1] && req_op_i[3:2] == 2'd1)) |=> !gnt_o[3]);           // R4
        AST_FMA_PRIORITY: assert property (@(posedge clk_i) disable iff (rst_i)
            (req_vld_i[0] && req_op_i[1:0] == 2'd1 &&
             req_vld_i[1] && req_op_i[3:2] == 2'd1) |=> (gnt_o[0] && !gnt_o[1])); // R5
    end else begin : g_red
        AST_NO_FP3: assert property (@(posedge clk_i) disable iff (rst_i)
            !gnt_o[3] && !wr_en_o[3]);                                          // R2
    end
endmodule

bind fp_rdport_alloc fpa_checker #(.REDUCED(REDUCED)) u_fpa_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .req_vld_i (req_vld_i),
    .req_op_i  (req_op_i),
    .gnt_o     (gnt_o),
    .wr_en_o   (wr_en_o),
    .bad_op_o  (bad_op_o)
);

// File: tb/fp_rdport_alloc_bench.sv
`timescale 1ns/1ps
module fp_rdport_alloc_bench;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [3:0]      vld = '0;
    logic [7:0]      op  = '0;
    logic [12*AW-1:0] src = '0;

    logic [3:0] gF, wF, bF, gR, wR, bR;
    logic [7:0] enF;  logic [8*AW-1:0] adF;  logic [15:0] ppF;
    logic [5:0] enR;  logic [6*AW-1:0] adR;  logic [11:0] ppR;

    fp_rdport_alloc #(.REDUCED(1'b0), .REG_AW(AW)) u_fp_rdport_alloc (
        .clk_i(clk), .rst_i(rst), .req_vld_i(vld), .req_op_i(op), .req_src_i(src),
        .gnt_o(gF), .wr_en_o(wF), .bad_op_o(bF),
        .rd_en_o(enF), .rd_addr_o(adF), .rd_pipe_o(ppF));

    fp_rdport_alloc #(.REDUCED(1'b1), .REG_AW(AW)) u_fp_rdport_alloc_red (
        .clk_i(clk), .rst_i(rst), .req_vld_i(vld), .req_op_i(op), .req_src_i(src),
        .gnt_o(gR), .wr_en_o(wR), .bad_op_o(bR),
        .rd_en_o(enR), .rd_addr_o(adR), .rd_pipe_o(ppR));

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    function automatic bit legal(bit red, int p, logic [1:0] c);
        if (c == 2'd3) return 1'b0;
        if (!red) begin
            case (p)
                0, 1:    return c != 2'd2;
                2:       return c != 2'd1;
                default: return c == 2'd0;
            endcase
        end
        case (p)
            0:       return c != 2'd2;
            1:       return c == 2'd0;
            2:       return c == 2'd2;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int pmap(bit red, int p, int s);
        if (!red) begin
            if (s < 2) return 2 * p + s;
            return (p < 2) ? 6 : -1;
        end
        case (p)
            0:       return s;
            1:       return (s < 2) ? 3 + s : -1;
            2:       return (s == 0) ? 5 : -1;
            default: return -1;
        endcase
    endfunction

    function automatic int nsrc(logic [1:0] c);
        return (c == 2'd2) ? 1 : (c == 2'd1) ? 3 : 2;
    endfunction

    task automatic model(input bit red, output logic [3:0] g, output logic [3:0] w,
                         output logic [3:0] b, output logic [7:0] en,
                         output logic [8*AW-1:0] ad, output logic [15:0] pp);
        logic [3:0] fma;
        g = '0; w = '0; b = '0; en = '0; ad = '0; pp = '0; fma = '0;
        for (int p = 0; p < 4; p++) begin
            g[p]   = vld[p] && legal(red, p, op[2*p+:2]);
            b[p]   = vld[p] && !legal(red, p, op[2*p+:2]);
            fma[p] = g[p] && op[2*p+:2] == 2'd1;
        end
        if (!red && fma[0] && fma[1]) g[1] = 1'b0;
        if (!red && (fma[0] || fma[1])) g[3] = 1'b0;
        for (int p = 0; p < 4; p++) begin
            w[p] = g[p] && op[2*p+:2] != 2'd2;
            for (int s = 0; s < 3; s++) begin
                if (g[p] && s < nsrc(op[2*p+:2]) && pmap(red, p, s) >= 0) begin
                    en[pmap(red, p, s)] = 1'b1;
                    ad[pmap(red, p, s)*AW +: AW] = src[(3*p+s)*AW +: AW];
                    pp[pmap(red, p, s)*2 +: 2] = 2'(p);
                end
            end
        end
    endtask

    task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    logic [3:0] pgF = '0, pgR = '0;

    task automatic step(string tag, logic [3:0] v, logic [7:0] o, logic [12*AW-1:0] s);
        logic [3:0] egF, ewF, ebF, egR, ewR, ebR;
        logic [7:0] eeF, eeR; logic [8*AW-1:0] eaF, eaR; logic [15:0] epF, epR;
        @(negedge clk);
        vld = v; op = o; src = s;
        model(1'b0, egF, ewF, ebF, eeF, eaF, epF);
        model(1'b1, egR, ewR, ebR, eeR, eaR, epR);
        #1;
        chk("R8", "full grant before edge", 128'(gF), 128'(pgF));
        chk("R8", "reduced grant before edge", 128'(gR), 128'(pgR));
        @(posedge clk); #1;
        chk(tag, "full gnt", 128'(gF), 128'(egF));
        chk("R7", "full wr_en", 128'(wF), 128'(ewF));
        chk("R3", "full bad_op", 128'(bF), 128'(ebF));
        chk("R1", "full rd_en", 128'(enF), 128'(eeF));
        chk("R1", "full rd_addr", 128'(adF), 128'(eaF));
        chk("R1", "full rd_pipe", 128'(ppF), 128'(epF));
        chk(tag, "reduced gnt", 128'(gR), 128'(egR));
        chk("R7", "reduced wr_en", 128'(wR), 128'(ewR));
        chk("R3", "reduced bad_op", 128'(bR), 128'(ebR));
        chk("R2", "reduced rd_en", 128'(enR), 128'(eeR[5:0]));
        chk("R2", "reduced rd_addr", 128'(adR), 128'(eaR[6*AW-1:0]));
        chk("R2", "reduced rd_pipe", 128'(ppR), 128'(epR[11:0]));
        pgF = egF; pgR = egR;
    endtask

    function automatic logic [12*AW-1:0] seq_src(int base);
        logic [12*AW-1:0] r;
        for (int i = 0; i < 12; i++) r[i*AW +: AW] = AW'(base + i);
        return r;
    endfunction

    initial begin
        void'($urandom(32'd715));
        // R9: outputs stay zero during reset even with live requests
        vld = 4'hF; op = 8'h00; src = seq_src(16);
        repeat (3) @(posedge clk);
        #1;
        chk("R9", "full outputs in reset", 128'({gF, wF, bF, enF, adF, ppF}), 128'(0));
        chk("R9", "reduced outputs in reset", 128'({gR, wR, bR, enR, adR, ppR}), 128'(0));
        @(negedge clk); rst = 1'b0; vld = '0;
        @(posedge clk); #1;

        step("R3", 4'hF, 8'b00_00_00_00, seq_src(32));            // math everywhere
        step("R4", 4'b1001, 8'b00_00_00_01, seq_src(48));         // FP0 fma vs FP3 math
        step("R4", 4'b1010, 8'b00_00_01_00, seq_src(64));         // FP1 fma vs FP3 math
        step("R5", 4'b1011, 8'b00_00_01_01, seq_src(80));         // both fma
        step("R6", 4'b0100, 8'b00_10_00_00, seq_src(96));         // lone store on FP2
        step("R6", 4'hF, 8'b11_10_00_01, seq_src(112));           // mixed with store
        step("R3", 4'hF, 8'b11_11_11_11, seq_src(128));           // reserved class
        step("R3", 4'b0110, 8'b00_01_10_00, seq_src(144));        // wrong pipe classes
        step("R8", 4'h0, 8'hFF, seq_src(160));                    // idle: ports clear
        step("R5", 4'b0011, 8'b00_00_01_01, seq_src(176));        // both fma, no FP3

        for (int n = 0; n < 400; n++) begin
            logic [12*AW-1:0] rs;
            for (int i = 0; i < 12; i++) rs[i*AW +: AW] = AW'($urandom);
            step("R3", 4'($urandom), 8'($urandom), rs);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule